// File: doc/BRIEF.md
# Dual-Accumulator Data Arithmetic Unit

This block is the arithmetic core of a 16-bit fixed-point signal processor. It holds two 36-bit accumulators, a 32-bit product register and two 16-bit operand registers (x and y). Each accumulator has a 4-bit guard extension above a 16-bit high half and a 16-bit low half. A status word of four condition flags sits beside them. Each cycle in which `op_valid` is high, the unit executes one function code. The code comes from one of two 16-entry maps, chosen by `op_is_f2`. A source select and a destination select name the accumulator that is read and the one that is written.

The first map is a multiply-accumulate map with a pipelined product. The product left by an earlier operation is merged into an accumulator while x*y is formed into the product register in the same cycle. The map also holds logic operations, additions and subtractions against y, and two compare-style codes that only set flags. The second map shifts (right and arithmetic, or left) by 1, 4, 8 or 16 places. It also rounds, increments the whole value or only the high half, copies, negates, and loads p or y. One of its codes is reserved and is reported as illegal. Operands arrive through load ports. Addressing, memory and instruction fetch belong to neighbouring blocks. An alignment-control value is carried through unchanged for the neighbour that owns it.

Top module: `accum_dau`

## Requirements
- R1: While `rst_n` is low at a clock edge, both accumulators, the product register, x, y and the status word are cleared to zero.
- R2: Map 1 (`op_is_f2`=0) product codes use the product value from before the edge. 0 writes aD=p, 1 writes aD=aS+p, 3 writes aD=aS-p, and each also loads p=x*y. 2 only loads p=x*y. 4, 5 and 7 are aD=p, aD=aS+p and aD=aS-p and leave p unchanged. p is a signed 32-bit value, sign-extended to 36 bits when used.
- R3: Map 1 codes 8, 9, 14 and 15 write aS OR Y, aS XOR Y, aS AND Y and aS-Y. Code 13 writes aS+Y and code 12 writes Y. Y is y placed in bits 31:16, sign-extended through bits 35:32, with bits 15:0 zero.
- R4: Map 1 code 10 (aS AND Y) and code 11 (aS-Y) update only the status word. Code 6 changes nothing.
- R5: Map 2 codes 0 to 7 shift aS into aD. Even codes shift right arithmetically and odd codes shift left. Codes 0/1 shift by 1, 2/3 by 4, 4/5 by 8 and 6/7 by 16.
- R6: Map 2 code 8 writes aD=p and code 12 writes aD=Y. Code 9 writes aS+2^16, code 13 writes aS+1, code 14 copies aS and code 15 writes 0-aS.
- R7: Map 2 code 11 rounds: aD = aS + 0x8000 with bits 15:0 then cleared.
- R8: Map 2 code 10 is reserved. In that cycle `illegal_op` is high, and no register changes. `illegal_op` is low at all other times.
- R9: Every operation that writes an accumulator, and map 1 codes 10 and 11, load the status word from the 36-bit result. Bit 3 is the sign bit 35. Bit 2 is set when the result is zero. Bit 1 is set when bits 35:31 are not all equal (the result does not fit 32 bits). Bit 0 is set when the 36-bit signed add, subtract, negate, increment or round overflowed; it is 0 for other codes. Map 1 codes 2 and 6 leave the status word unchanged.
- R10: Only the accumulator named by `dst_acc` (0 = a0, 1 = a1) can change. `src_acc` may name the same accumulator.
- R11: With `op_valid` low nothing but x and y changes. `x_load`/`y_load` take effect at the edge, so an operation in the same cycle uses the earlier x and y.
- R12: `align_ctl_o` always equals `align_ctl_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Execute the function code this cycle |
| op_is_f2 | input | 1 | 0 selects map 1, 1 selects map 2 |
| func_code | input | 4 | Function code within the selected map |
| src_acc | input | 1 | Source accumulator select |
| dst_acc | input | 1 | Destination accumulator select |
| x_load | input | 1 | Load x from x_data |
| x_data | input | 16 | New x operand |
| y_load | input | 1 | Load y from y_data |
| y_data | input | 16 | New y operand |
| align_ctl_i | input | 8 | Alignment-control value from its owner |
| align_ctl_o | output | 8 | Same value, passed through |
| acc0_o | output | 36 | Accumulator a0 |
| acc1_o | output | 36 | Accumulator a1 |
| prod_o | output | 32 | Product register p |
| flags_o | output | 4 | Status word {minus, zero, fit-overflow, math-overflow} |
| illegal_op | output | 1 | Reserved code executed this cycle |

## Verification
The bench goes after the product pipeline. A design that merged the new x*y instead of the previous p would give the wrong value after a code 1 that directly follows a code 2. It negates the most negative 36-bit value, where a missing overflow flag or a wrapped sign would show. It rounds a value whose bit 15 is set, where a design that forgot to clear the low half, or added at the wrong place, gives the wrong high half. It also shifts a value across bit 31 to raise only the fit-overflow flag, runs the reserved code against a design that might write anyway, and loads x in the same cycle as a multiply to catch a design that used the new operand.

// File: rtl/accum_pkg.sv
// Shared codes and flag positions of the dual-accumulator arithmetic unit.
// Assumes: function codes are 4 bits; the flag word is 4 bits wide.
package accum_pkg;

    localparam int FLAG_W   = 4;
    localparam int FL_MINUS = 3;
    localparam int FL_ZERO  = 2;
    localparam int FL_FIT   = 1;
    localparam int FL_MATH  = 0;

    // Map 1: product pipeline, logic and add/subtract against y
    typedef enum logic [3:0] {
        M1_MOVP_MUL = 4'h0,
        M1_ADDP_MUL = 4'h1,
        M1_MUL_ONLY = 4'h2,
        M1_SUBP_MUL = 4'h3,
        M1_MOVP     = 4'h4,
        M1_ADDP     = 4'h5,
        M1_IDLE     = 4'h6,
        M1_SUBP     = 4'h7,
        M1_ORY      = 4'h8,
        M1_XORY     = 4'h9,
        M1_TSTY     = 4'hA,
        M1_CMPY     = 4'hB,
        M1_MOVY     = 4'hC,
        M1_ADDY     = 4'hD,
        M1_ANDY     = 4'hE,
        M1_SUBY     = 4'hF
    } map1_code_e;

    // Map 2: fixed shifts, round, increment, negate, moves
    typedef enum logic [3:0] {
        M2_SHR1  = 4'h0,
        M2_SHL1  = 4'h1,
        M2_SHR4  = 4'h2,
        M2_SHL4  = 4'h3,
        M2_SHR8  = 4'h4,
        M2_SHL8  = 4'h5,
        M2_SHR16 = 4'h6,
        M2_SHL16 = 4'h7,
        M2_MOVP  = 4'h8,
        M2_INCHI = 4'h9,
        M2_RSVD  = 4'hA,
        M2_RND   = 4'hB,
        M2_MOVY  = 4'hC,
        M2_INC   = 4'hD,
        M2_COPY  = 4'hE,
        M2_NEG   = 4'hF
    } map2_code_e;

endpackage

// File: rtl/accum_addsub.sv
// Two's-complement adder/subtractor with signed overflow detection.
// Assumes: sub=1 computes a-b; overflow is for W-bit signed operands.
module accum_addsub #(
    parameter int W = 36
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    // Invert b for subtraction and form the sum with carry-in
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/accum_map1.sv
// Map 1 datapath: product merges, logic and add/subtract against y.
// Assumes: prod_ext and y_ext are already aligned to the accumulator width.
module accum_map1
    import accum_pkg::*;
#(
    parameter int W = 36
) (
    input  logic [3:0]   code,
    input  logic [W-1:0] acc_s,
    input  logic [W-1:0] prod_ext,
    input  logic [W-1:0] y_ext,
    output logic [W-1:0] res,
    output logic         acc_we,
    output logic         flag_we,
    output logic         prod_we,
    output logic         math_ovf
);
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         op_sub;
    logic [W-1:0] sum;
    logic         sum_ovf;
    logic         use_logic;
    logic [W-1:0] logic_res;

    // Choose adder operands and logic result per code
    always_comb begin
        op_a      = acc_s;
        op_b      = y_ext;
        op_sub    = 1'b0;
        use_logic = 1'b0;
        logic_res = acc_s & y_ext;
        acc_we    = 1'b1;
        flag_we   = 1'b1;
        prod_we   = 1'b0;
        unique case (map1_code_e'(code))
            M1_MOVP_MUL: begin op_a = '0;    op_b = prod_ext; prod_we = 1'b1; end
            M1_ADDP_MUL: begin op_b = prod_ext; prod_we = 1'b1; end
            M1_MUL_ONLY: begin acc_we = 1'b0; flag_we = 1'b0; prod_we = 1'b1; end
            M1_SUBP_MUL: begin op_b = prod_ext; op_sub = 1'b1; prod_we = 1'b1; end
            M1_MOVP:     begin op_a = '0;    op_b = prod_ext; end
            M1_ADDP:     begin op_b = prod_ext; end
            M1_IDLE:     begin acc_we = 1'b0; flag_we = 1'b0; end
            M1_SUBP:     begin op_b = prod_ext; op_sub = 1'b1; end
            M1_ORY:      begin use_logic = 1'b1; logic_res = acc_s | y_ext; end
            M1_XORY:     begin use_logic = 1'b1; logic_res = acc_s ^ y_ext; end
            M1_TSTY:     begin use_logic = 1'b1; acc_we = 1'b0; end
            M1_CMPY:     begin op_sub = 1'b1; acc_we = 1'b0; end
            M1_MOVY:     begin op_a = '0; end
            M1_ADDY:     begin end
            M1_ANDY:     begin use_logic = 1'b1; end
            M1_SUBY:     begin op_sub = 1'b1; end
            default:     begin acc_we = 1'b0; flag_we = 1'b0; end
        endcase
    end

    accum_addsub #(.W(W)) u_add (
        .a   (op_a),
        .b   (op_b),
        .sub (op_sub),
        .sum (sum),
        .ovf (sum_ovf)
    );

    // Pick the final result and its overflow indication
    always_comb begin
        res      = use_logic ? logic_res : sum;
        math_ovf = use_logic ? 1'b0 : sum_ovf;
    end
endmodule

// File: rtl/accum_map2.sv
// Map 2 datapath: fixed-distance shifts, round, increments, negate, moves.
// Assumes: LW is the width of the low half; shift distances are 1,4,8,16.
module accum_map2
    import accum_pkg::*;
#(
    parameter int W  = 36,
    parameter int LW = 16
) (
    input  logic [3:0]   code,
    input  logic [W-1:0] acc_s,
    input  logic [W-1:0] prod_ext,
    input  logic [W-1:0] y_ext,
    output logic [W-1:0] res,
    output logic         acc_we,
    output logic         math_ovf,
    output logic         reserved
);
    localparam int NSH = 4;

    logic [W-1:0] shr [NSH];
    logic [W-1:0] shl [NSH];

    // One right and one left shifter per fixed distance
    for (genvar g = 0; g < NSH; g++) begin : g_shift
        localparam int DIST = (g == 0) ? 1 : (4 << (g - 1));
        assign shr[g] = W'($signed(acc_s) >>> DIST);
        assign shl[g] = acc_s << DIST;
    end

    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         op_sub;
    logic [W-1:0] sum;
    logic         sum_ovf;
    logic         is_shift;
    logic         clr_low;

    // Choose adder operands per code
    always_comb begin
        op_a     = acc_s;
        op_b     = '0;
        op_sub   = 1'b0;
        is_shift = 1'b0;
        clr_low  = 1'b0;
        acc_we   = 1'b1;
        reserved = 1'b0;
        unique case (map2_code_e'(code))
            M2_SHR1, M2_SHL1, M2_SHR4, M2_SHL4,
            M2_SHR8, M2_SHL8, M2_SHR16, M2_SHL16: is_shift = 1'b1;
            M2_MOVP:  begin op_a = '0; op_b = prod_ext; end
            M2_INCHI: op_b[LW] = 1'b1;
            M2_RSVD:  begin acc_we = 1'b0; reserved = 1'b1; end
            M2_RND:   begin op_b[LW-1] = 1'b1; clr_low = 1'b1; end
            M2_MOVY:  begin op_a = '0; op_b = y_ext; end
            M2_INC:   op_b[0] = 1'b1;
            M2_COPY:  begin end
            M2_NEG:   begin op_a = '0; op_b = acc_s; op_sub = 1'b1; end
            default:  acc_we = 1'b0;
        endcase
    end

    accum_addsub #(.W(W)) u_add (
        .a   (op_a),
        .b   (op_b),
        .sub (op_sub),
        .sum (sum),
        .ovf (sum_ovf)
    );

    // Form the result: shifter output, rounded sum or plain sum
    always_comb begin
        if (is_shift) begin
            res      = code[0] ? shl[code[2:1]] : shr[code[2:1]];
            math_ovf = 1'b0;
        end else if (clr_low) begin
            res      = {sum[W-1:LW], {LW{1'b0}}};
            math_ovf = sum_ovf;
        end else begin
            res      = sum;
            math_ovf = sum_ovf;
        end
    end
endmodule

// File: rtl/accum_status.sv
// Derives the four condition flags from a 36-bit result.
// Assumes: FIT_LSB is the top bit of the 32-bit signed range (bit 31).
module accum_status
    import accum_pkg::*;
#(
    parameter int W       = 36,
    parameter int FIT_LSB = 31
) (
    input  logic [W-1:0]      res,
    input  logic              math_ovf,
    output logic [FLAG_W-1:0] flags
);
    logic [W-1:FIT_LSB] top;

    // Compute sign, zero, fit and math-overflow flags
    always_comb begin
        top             = res[W-1:FIT_LSB];
        flags           = '0;
        flags[FL_MINUS] = res[W-1];
        flags[FL_ZERO]  = (res == '0);
        flags[FL_FIT]   = !((&top) || !(|top));
        flags[FL_MATH]  = math_ovf;
    end
endmodule

// File: rtl/accum_dau.sv
// Dual-accumulator arithmetic unit: registers, operand alignment, map select.
// Assumes: one operation per cycle; loads of x/y take effect at the edge.
module accum_dau
    import accum_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 4,
    parameter int ALIGN_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            op_valid,
    input  logic                            op_is_f2,
    input  logic [3:0]                      func_code,
    input  logic                            src_acc,
    input  logic                            dst_acc,
    input  logic                            x_load,
    input  logic [DATA_W-1:0]               x_data,
    input  logic                            y_load,
    input  logic [DATA_W-1:0]               y_data,
    input  logic [ALIGN_W-1:0]              align_ctl_i,
    output logic [ALIGN_W-1:0]              align_ctl_o,
    output logic [GUARD_W+2*DATA_W-1:0]     acc0_o,
    output logic [GUARD_W+2*DATA_W-1:0]     acc1_o,
    output logic [2*DATA_W-1:0]             prod_o,
    output logic [FLAG_W-1:0]               flags_o,
    output logic                            illegal_op
);
    localparam int PROD_W  = 2 * DATA_W;
    localparam int ACC_W   = GUARD_W + PROD_W;
    localparam int NUM_ACC = 2;

    logic [ACC_W-1:0]  acc_q [NUM_ACC];
    logic [PROD_W-1:0] prod_q;
    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] y_q;
    logic [FLAG_W-1:0] flags_q;

    logic [ACC_W-1:0]  acc_s;
    logic [ACC_W-1:0]  prod_ext;
    logic [ACC_W-1:0]  y_ext;
    logic [PROD_W-1:0] product;

    // Align operands to the accumulator and form the new product
    always_comb begin
        acc_s    = acc_q[src_acc];
        prod_ext = {{GUARD_W{prod_q[PROD_W-1]}}, prod_q};
        y_ext    = {{GUARD_W{y_q[DATA_W-1]}}, y_q, {DATA_W{1'b0}}};
        product  = $signed({{DATA_W{x_q[DATA_W-1]}}, x_q})
                 * $signed({{DATA_W{y_q[DATA_W-1]}}, y_q});
    end

    logic [ACC_W-1:0] m1_res;
    logic             m1_acc_we, m1_flag_we, m1_prod_we, m1_ovf;
    logic [ACC_W-1:0] m2_res;
    logic             m2_acc_we, m2_ovf, m2_rsvd;

    accum_map1 #(.W(ACC_W)) u_map1 (
        .code     (func_code),
        .acc_s    (acc_s),
        .prod_ext (prod_ext),
        .y_ext    (y_ext),
        .res      (m1_res),
        .acc_we   (m1_acc_we),
        .flag_we  (m1_flag_we),
        .prod_we  (m1_prod_we),
        .math_ovf (m1_ovf)
    );

    accum_map2 #(.W(ACC_W), .LW(DATA_W)) u_map2 (
        .code     (func_code),
        .acc_s    (acc_s),
        .prod_ext (prod_ext),
        .y_ext    (y_ext),
        .res      (m2_res),
        .acc_we   (m2_acc_we),
        .math_ovf (m2_ovf),
        .reserved (m2_rsvd)
    );

    logic [ACC_W-1:0]  res;
    logic              math_ovf;
    logic              acc_we, flag_we, prod_we;
    logic [FLAG_W-1:0] flags_new;

    // Select the active map and gate its write enables with op_valid
    always_comb begin
        res      = op_is_f2 ? m2_res : m1_res;
        math_ovf = op_is_f2 ? m2_ovf : m1_ovf;
        acc_we   = op_valid && (op_is_f2 ? m2_acc_we : m1_acc_we);
        flag_we  = op_valid && (op_is_f2 ? m2_acc_we : m1_flag_we);
        prod_we  = op_valid && !op_is_f2 && m1_prod_we;
    end

    accum_status #(.W(ACC_W), .FIT_LSB(PROD_W - 1)) u_status (
        .res      (res),
        .math_ovf (math_ovf),
        .flags    (flags_new)
    );

    // One register per accumulator, written only when selected as destination
    for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[i] <= '0;
            else if (acc_we && (32'(dst_acc) == i))
                acc_q[i] <= res;
        end
    end

    // Product, operand and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            x_q     <= '0;
            y_q     <= '0;
            flags_q <= '0;
        end else begin
            if (prod_we) prod_q  <= product;
            if (x_load)  x_q     <= x_data;
            if (y_load)  y_q     <= y_data;
            if (flag_we) flags_q <= flags_new;
        end
    end

    // Drive the outputs
    always_comb begin
        align_ctl_o = align_ctl_i;
        acc0_o      = acc_q[0];
        acc1_o      = acc_q[1];
        prod_o      = prod_q;
        flags_o     = flags_q;
        illegal_op  = op_valid && op_is_f2 && m2_rsvd;
    end
endmodule

// File: rtl/accum_dau_checker.sv
// Temporal properties of the arithmetic unit, bound onto accum_dau.
// Assumes: observes only ports of the top module.
module accum_dau_checker #(
    parameter int ACC_W  = 36,
    parameter int PROD_W = 32,
    parameter int FLAG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_is_f2,
    input logic [3:0]        func_code,
    input logic              dst_acc,
    input logic [ACC_W-1:0]  acc0_o,
    input logic [ACC_W-1:0]  acc1_o,
    input logic [PROD_W-1:0] prod_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              illegal_op
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (acc0_o == '0 && acc1_o == '0 && prod_o == '0 && flags_o == '0));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc0_o) && $stable(acc1_o) && $stable(prod_o) && $stable(flags_o)));

    p_reserved_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> ($stable(acc0_o) && $stable(acc1_o) && $stable(prod_o) && $stable(flags_o)));

    p_dst1_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && dst_acc) |=> $stable(acc0_o));

    p_dst0_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !dst_acc) |=> $stable(acc1_o));

    p_flag_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_is_f2 && (func_code == 4'hA || func_code == 4'hB || func_code == 4'h6))
        |=> ($stable(acc0_o) && $stable(acc1_o)));

    p_copy_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_f2 && func_code == 4'hE && !dst_acc)
        |=> (flags_o[3] == acc0_o[ACC_W-1] && flags_o[2] == (acc0_o == '0)));
endmodule

bind accum_dau accum_dau_checker #(
    .ACC_W  (GUARD_W + 2*DATA_W),
    .PROD_W (2*DATA_W),
    .FLAG_W (accum_pkg::FLAG_W)
) i_accum_dau_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_is_f2   (op_is_f2),
    .func_code  (func_code),
    .dst_acc    (dst_acc),
    .acc0_o     (acc0_o),
    .acc1_o     (acc1_o),
    .prod_o     (prod_o),
    .flags_o    (flags_o),
    .illegal_op (illegal_op)
);

// File: tb/test_accum_dau.sv
module test_accum_dau;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_is_f2, src_acc, dst_acc;
    logic [3:0]  func_code;
    logic        x_load, y_load;
    logic [15:0] x_data, y_data;
    logic [7:0]  align_ctl_i, align_ctl_o;
    logic [35:0] acc0_o, acc1_o;
    logic [31:0] prod_o;
    logic [3:0]  flags_o;
    logic        illegal_op;

    always #5 clk = ~clk;

    accum_dau i_accum_dau (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_f2(op_is_f2),
        .func_code(func_code), .src_acc(src_acc), .dst_acc(dst_acc),
        .x_load(x_load), .x_data(x_data), .y_load(y_load), .y_data(y_data),
        .align_ctl_i(align_ctl_i), .align_ctl_o(align_ctl_o),
        .acc0_o(acc0_o), .acc1_o(acc1_o), .prod_o(prod_o),
        .flags_o(flags_o), .illegal_op(illegal_op)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    logic [35:0] m_acc [2];
    logic [31:0] m_p;
    logic [15:0] m_x, m_y;
    logic [3:0]  m_fl;

    // Operation table: {map2, code, src, dst}
    localparam logic [6:0] OPS [32] = '{
        {1'b0,4'h0,1'b0,1'b1}, {1'b0,4'h1,1'b1,1'b0}, {1'b0,4'h2,1'b0,1'b0}, {1'b0,4'h3,1'b0,1'b1},
        {1'b0,4'h4,1'b1,1'b1}, {1'b0,4'h5,1'b0,1'b0}, {1'b0,4'h6,1'b1,1'b0}, {1'b0,4'h7,1'b1,1'b0},
        {1'b0,4'h8,1'b0,1'b1}, {1'b0,4'h9,1'b1,1'b0}, {1'b0,4'hA,1'b0,1'b1}, {1'b0,4'hB,1'b1,1'b1},
        {1'b0,4'hC,1'b0,1'b0}, {1'b0,4'hD,1'b0,1'b1}, {1'b0,4'hE,1'b1,1'b0}, {1'b0,4'hF,1'b1,1'b1},
        {1'b1,4'h0,1'b0,1'b1}, {1'b1,4'h1,1'b1,1'b0}, {1'b1,4'h2,1'b0,1'b0}, {1'b1,4'h3,1'b1,1'b1},
        {1'b1,4'h4,1'b0,1'b1}, {1'b1,4'h5,1'b1,1'b0}, {1'b1,4'h6,1'b0,1'b0}, {1'b1,4'h7,1'b1,1'b1},
        {1'b1,4'h8,1'b0,1'b1}, {1'b1,4'h9,1'b1,1'b0}, {1'b1,4'hA,1'b0,1'b1}, {1'b1,4'hB,1'b1,1'b1},
        {1'b1,4'hC,1'b0,1'b0}, {1'b1,4'hD,1'b0,1'b1}, {1'b1,4'hE,1'b1,1'b0}, {1'b1,4'hF,1'b0,1'b0}
    };

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic f2, input logic [3:0] c);
        if (!f2) begin
            if (c inside {4'h0,4'h1,4'h2,4'h3,4'h4,4'h5,4'h7}) return "R2";
            if (c inside {4'h6,4'hA,4'hB}) return "R4";
            return "R3";
        end
        if (c <= 4'h7) return "R5";
        if (c == 4'hA) return "R8";
        if (c == 4'hB) return "R7";
        return "R6";
    endfunction

    function automatic logic signed [39:0] sx(input logic [35:0] v);
        return {{4{v[35]}}, v};
    endfunction

    // Reference model of one operation, from the requirements
    task automatic model_op(input logic f2, input logic [3:0] c, input logic s, input logic d);
        logic signed [39:0] a_s, pv, yv, w;
        logic [35:0] r;
        bit wr, fw, pw;
        a_s = sx(m_acc[s]);
        pv  = {{8{m_p[31]}}, m_p};
        yv  = {{8{m_y[15]}}, m_y, 16'h0};
        wr = 1; fw = 1; pw = 0; w = 0;
        if (!f2) begin
            case (c)
                4'h0: begin w = pv; pw = 1; end
                4'h1: begin w = a_s + pv; pw = 1; end
                4'h2: begin wr = 0; fw = 0; pw = 1; end
                4'h3: begin w = a_s - pv; pw = 1; end
                4'h4: w = pv;
                4'h5: w = a_s + pv;
                4'h6: begin wr = 0; fw = 0; end
                4'h7: w = a_s - pv;
                4'h8: w = sx(m_acc[s] | yv[35:0]);
                4'h9: w = sx(m_acc[s] ^ yv[35:0]);
                4'hA: begin w = sx(m_acc[s] & yv[35:0]); wr = 0; end
                4'hB: begin w = a_s - yv; wr = 0; end
                4'hC: w = yv;
                4'hD: w = a_s + yv;
                4'hE: w = sx(m_acc[s] & yv[35:0]);
                default: w = a_s - yv;
            endcase
        end else begin
            case (c)
                4'h0: w = a_s >>> 1;
                4'h1: w = sx(m_acc[s] << 1);
                4'h2: w = a_s >>> 4;
                4'h3: w = sx(m_acc[s] << 4);
                4'h4: w = a_s >>> 8;
                4'h5: w = sx(m_acc[s] << 8);
                4'h6: w = a_s >>> 16;
                4'h7: w = sx(m_acc[s] << 16);
                4'h8: w = pv;
                4'h9: w = a_s + 40'sh10000;
                4'hA: begin wr = 0; fw = 0; end
                4'hB: w = (a_s + 40'sh8000) & ~40'shFFFF;
                4'hC: w = yv;
                4'hD: w = a_s + 40'sh1;
                4'hE: w = a_s;
                default: w = 40'sh0 - a_s;
            endcase
        end
        r = w[35:0];
        if (fw) m_fl = {r[35], r == 36'h0, !((&r[35:31]) || !(|r[35:31])), w != sx(r)};
        if (wr) m_acc[d] = r;
        if (pw) m_p = 32'($signed(m_x) * $signed(m_y));
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "acc0", 64'(acc0_o), 64'(m_acc[0]));
        chk(tag, "acc1", 64'(acc1_o), 64'(m_acc[1]));
        chk(tag, "prod", 64'(prod_o), 64'(m_p));
        chk(tag, "flags", 64'(flags_o), 64'(m_fl));
    endtask

    // Load x and y (one cycle), called just after a falling edge
    task automatic load_xy(input logic [15:0] xv, input logic [15:0] yv);
        x_load = 1; y_load = 1; x_data = xv; y_data = yv;
        @(negedge clk);
        x_load = 0; y_load = 0;
        m_x = xv; m_y = yv;
    endtask

    // Execute one operation and compare everything with the model
    task automatic run_op(input logic f2, input logic [3:0] c, input logic s, input logic d);
        string tag;
        tag = req_of(f2, c);
        op_valid = 1; op_is_f2 = f2; func_code = c; src_acc = s; dst_acc = d;
        #1;
        chk("R8", "illegal_op", 64'(illegal_op), 64'(f2 && c == 4'hA));
        @(negedge clk);
        op_valid = 0;
        model_op(f2, c, s, d);
        compare_all(tag);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] x0, x1;
        void'($urandom(32'h1234_5678));
        rst_n = 0; op_valid = 0; op_is_f2 = 0; func_code = 0; src_acc = 0; dst_acc = 0;
        x_load = 0; y_load = 0; x_data = 0; y_data = 0; align_ctl_i = 0;
        m_acc[0] = 0; m_acc[1] = 0; m_p = 0; m_x = 0; m_y = 0; m_fl = 0;
        repeat (3) @(negedge clk);
        compare_all("R1");
        chk("R1", "illegal_op", 64'(illegal_op), 64'h0);
        rst_n = 1;
        @(negedge clk);

        // R12 pass-through
        align_ctl_i = 8'hA5; #1;
        chk("R12", "align", 64'(align_ctl_o), 64'hA5);
        align_ctl_i = 8'h3C; #1;
        chk("R12", "align", 64'(align_ctl_o), 64'h3C);

        // Seed both accumulators and the product
        load_xy(16'($urandom), 16'($urandom)); run_op(0, 4'hC, 0, 0);
        load_xy(16'($urandom), 16'($urandom)); run_op(0, 4'hC, 0, 1);
        run_op(0, 4'h2, 0, 0);

        // Table walk with random operands
        for (int pass = 0; pass < 4; pass++) begin
            for (int i = 0; i < 32; i++) begin
                load_xy(16'($urandom), 16'($urandom));
                run_op(OPS[i][6], OPS[i][5:2], OPS[i][1], OPS[i][0]);
            end
        end

        // R11: op_valid low changes nothing
        op_valid = 0; op_is_f2 = 0; func_code = 4'hC; dst_acc = 0;
        repeat (2) @(negedge clk);
        compare_all("R11");

        // R11: x load in the same cycle as a multiply uses the old x
        load_xy(16'd3, 16'd5);
        op_valid = 1; op_is_f2 = 0; func_code = 4'h2; x_load = 1; x_data = 16'd7;
        @(negedge clk);
        op_valid = 0; x_load = 0;
        chk("R11", "prod old x", 64'(prod_o), 64'd15);
        m_p = 32'd15; m_x = 16'd7;
        run_op(0, 4'h2, 0, 0);
        chk("R11", "prod new x", 64'(prod_o), 64'd35);

        // R2: pipelined merge of the old product
        load_xy(16'd2, 16'd7);
        run_op(0, 4'hC, 0, 0);
        chk("R3", "y aligned", 64'(acc0_o), 64'h0_0007_0000);
        run_op(0, 4'h1, 0, 1);
        chk("R2", "acc1 old p", 64'(acc1_o), 64'h0_0007_0023);
        chk("R2", "new p", 64'(prod_o), 64'd14);

        // R7: round up at bit 15
        load_xy(16'd0, 16'h0080);
        run_op(0, 4'hC, 0, 0);
        run_op(1, 4'h4, 0, 0);
        chk("R5", "shr8", 64'(acc0_o), 64'h0_0000_8000);
        run_op(1, 4'hB, 0, 1);
        chk("R7", "round", 64'(acc1_o), 64'h0_0001_0000);

        // R6/R9: negate the most negative value
        load_xy(16'd0, 16'h8000);
        run_op(0, 4'hC, 0, 0);
        run_op(1, 4'h3, 0, 0);
        chk("R5", "shl4", 64'(acc0_o), 64'h8_0000_0000);
        run_op(1, 4'hF, 0, 0);
        chk("R6", "neg min", 64'(acc0_o), 64'h8_0000_0000);
        chk("R9", "neg flags", 64'(flags_o), 64'hB);

        // R9: shift across bit 31 raises only the fit flag
        load_xy(16'd0, 16'h4000);
        run_op(0, 4'hC, 0, 1);
        run_op(1, 4'h1, 1, 1);
        chk("R9", "fit ovf value", 64'(acc1_o), 64'h0_8000_0000);
        chk("R9", "fit ovf flags", 64'(flags_o), 64'h2);

        // R9: zero result
        load_xy(16'd0, 16'h0000);
        run_op(0, 4'hE, 1, 0);
        chk("R9", "zero flags", 64'(flags_o), 64'h4);

        // R4: compare-only leaves accumulators
        load_xy(16'd0, 16'h0001);
        x0 = 16'(acc1_o[15:0]);
        run_op(0, 4'hB, 1, 1);
        chk("R4", "cmp keeps acc1 low", 64'(acc1_o[15:0]), 64'(x0));

        // R8/R10: reserved code leaves all state
        run_op(1, 4'hA, 0, 1);
        x1 = 16'(acc1_o[31:16]);
        chk("R10", "acc1 high", 64'(x1), 64'h8000);

        done = 1'b1;
        report();
        $finish;
    end
endmodule